// File: doc/BRIEF.md
# Linear Photodiode Array Timing Generator

This block drives a self-scanning linear photodiode array from a single system clock. One start request runs one frame. The frame first waits until the current integration interval has run for at least the programmed time. It then issues the integration pulses: an active-low sample pulse, an active-high hold pulse that moves every pixel value into the hold stage at once, an active-low reset pulse that restarts integration on all pixels, and an active-high clamp pulse that overlaps a second active-low sample pulse.

After the integration pulses, the block scans the held values out. It drives an active-low start pulse and two complementary scan clocks. It raises an ADC trigger once for each pixel and raises an end-of-scan flag just before the last pixel. A busy flag covers the whole frame, and any start request made while busy is dropped.

All widths and periods are counted in system-clock cycles and set by parameters. The integration time comes in on a port and is clamped into a legal window.

Top module: `pda_timing_gen`

## Requirements
- R1: `busy` rises the cycle after a `start_req` seen while idle, and stays high until the scan ends. A `start_req` seen while `busy` is high has no effect on any output.
- R2: The integration pulses of a frame follow a fixed order with fixed widths. `sample_n` is low for SMP_W cycles. `hold` then rises in the same cycle that `sample_n` returns high and lasts HLD_W cycles. `reset_n` then falls as `hold` falls and stays low for RST_W cycles. `clamp` then rises together with a second `sample_n` low pulse, and both last RST_W cycles.
- R3: When idle or in reset, the outputs rest at these levels: `st_n`, `reset_n` and `sample_n` are 1; `hold`, `clamp`, `ck1`, `adc_trig`, `eos` and `busy` are 0; `ck2` is 1.
- R4: When a request waits on integration, `hold` rises exactly EFF+SMP_W+1 cycles after `reset_n` returned high in the previous frame. EFF is the effective integration length latched when the request is accepted.
- R5: EFF equals `integ_len` when `integ_len` lies within INT_MIN..INT_MAX. It equals INT_MIN below that range and INT_MAX above it.
- R6: `st_n` falls as `clamp` falls and stays low for 2*PH cycles. During that window `ck1` rises exactly once, and `st_n` returns high in the cycle that `ck1` falls.
- R7: `ck2` is the complement of `ck1` in every cycle. Each clock phase lasts PH cycles.
- R8: `adc_trig` is a one-cycle pulse issued in each cycle in which `ck2` rises during a scan. A frame has exactly NPIX of these pulses, spaced 2*PH cycles apart, and the first coincides with `st_n` rising.
- R9: `eos` rises together with the trigger of the second-to-last pixel. It falls together with the trigger of the last pixel, so it is high for 2*PH cycles.
- R10: `hold` is never high while `st_n` is low, while `ck1` is high, or while `eos` is high.
- R11: `gain_lvl` is the inverse of `hi_gain`: it is 1 for low gain and 0 for high gain.
- R12: `busy` falls PH cycles after the last pixel trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Frame request, taken only when idle |
| hi_gain | input | 1 | 1 selects high readout gain |
| integ_len | input | IW | Requested integration length in cycles |
| st_n | output | 1 | Scan start pulse, active low |
| ck1 | output | 1 | First scan clock |
| ck2 | output | 1 | Second scan clock, complement of ck1 |
| hold | output | 1 | Hold pulse, active high |
| reset_n | output | 1 | Integration reset pulse, active low |
| sample_n | output | 1 | Sample pulse, active low |
| clamp | output | 1 | Clamp pulse, active high |
| adc_trig | output | 1 | One-cycle conversion trigger per pixel |
| eos | output | 1 | End-of-scan flag, active high |
| busy | output | 1 | Frame in progress |
| gain_lvl | output | 1 | Gain pin level, high for low gain |

## Verification
The bench records every edge of the pulse outputs as a bitmask with its cycle distance from the previous edge, and compares each record against an expected event list built from the parameters. A pulse issued out of order, with a width off by one, or with a start window holding two clock rises produces a mismatched mask or gap. The integration interval from the end of reset to the next hold is measured for an in-range, a too-short and a too-long programmed length. A design that skips the clamp or waits one cycle too few would give the wrong interval. A request made during a scan must leave no trace, and a design that restarted on it would show an unexpected event. The end-of-scan window and the trigger count near the last pixel are checked, where an off-by-one in the pixel count would show up.

// File: rtl/pda_timing_gen.sv
module pda_timing_gen #(
  parameter int NPIX    = 64,
  parameter int PH      = 400,
  parameter int SMP_W   = 100,
  parameter int HLD_W   = 200,
  parameter int RST_W   = 3000,
  parameter int INT_MIN = 60000,
  parameter int INT_MAX = 2000000,
  parameter int IW      = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          hi_gain,
  input  logic [IW-1:0] integ_len,
  output logic          st_n,
  output logic          ck1,
  output logic          ck2,
  output logic          hold,
  output logic          reset_n,
  output logic          sample_n,
  output logic          clamp,
  output logic          adc_trig,
  output logic          eos,
  output logic          busy,
  output logic          gain_lvl
);
  localparam int CLP_W  = RST_W;
  localparam int TW     = $clog2(SMP_W + HLD_W + RST_W + 1) + 1;
  localparam int LAST_H = 2 * NPIX;
  localparam int HW     = $clog2(LAST_H + 1) + 1;
  localparam int PW     = $clog2(PH) + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SMP, S_HLD, S_RST, S_CLP, S_SCAN} state_t;

  state_t        st;
  logic [TW-1:0] cnt;
  logic [PW-1:0] pc;
  logic [HW-1:0] hc;
  logic [IW-1:0] icnt, eff_q, eff_c;
  logic          scan;

  assign eff_c = (integ_len < IW'(INT_MIN)) ? IW'(INT_MIN) :
                 (integ_len > IW'(INT_MAX)) ? IW'(INT_MAX) : integ_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      pc    <= '0;
      hc    <= '0;
      icnt  <= '0;
      eff_q <= IW'(INT_MIN);
    end else begin
      if (st == S_RST)               icnt <= '0;
      else if (icnt != IW'(INT_MAX)) icnt <= icnt + 1'b1;
      case (st)
        S_IDLE: if (start_req) begin
          st    <= S_WAIT;
          eff_q <= eff_c;
        end
        S_WAIT: if (icnt >= eff_q) begin
          st  <= S_SMP;
          cnt <= '0;
        end
        S_SMP: if (cnt == TW'(SMP_W - 1)) begin
          st  <= S_HLD;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_HLD: if (cnt == TW'(HLD_W - 1)) begin
          st  <= S_RST;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_RST: if (cnt == TW'(RST_W - 1)) begin
          st  <= S_CLP;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_CLP: if (cnt == TW'(CLP_W - 1)) begin
          st <= S_SCAN;
          pc <= '0;
          hc <= '0;
        end else cnt <= cnt + 1'b1;
        S_SCAN: if (pc == PW'(PH - 1)) begin
          pc <= '0;
          if (hc == HW'(LAST_H)) st <= S_IDLE;
          else                   hc <= hc + 1'b1;
        end else pc <= pc + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scan     = (st == S_SCAN);
  assign ck1      = scan & hc[0];
  assign ck2      = ~ck1;
  assign st_n     = ~(scan & (hc < HW'(2)));
  assign adc_trig = scan & (pc == '0) & (hc != '0) & ~hc[0];
  assign eos      = scan & (hc >= HW'(LAST_H - 2)) & (hc < HW'(LAST_H));
  assign hold     = (st == S_HLD);
  assign reset_n  = ~(st == S_RST);
  assign sample_n = ~((st == S_SMP) | (st == S_CLP));
  assign clamp    = (st == S_CLP);
  assign busy     = (st != S_IDLE);
  assign gain_lvl = ~hi_gain;

  assert_busy_on_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));
  assert_hold_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(!sample_n));
  assert_reset_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_n) |-> $past(hold));
  assert_clamp_after_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp) |-> $past(!reset_n) && !sample_n);
  assert_integ_elapsed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> icnt >= eff_q);
  assert_start_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_n) |-> $fell(ck1));
  assert_trig_on_ck2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> $rose(ck2));
  assert_eos_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eos) |-> adc_trig);
  assert_hold_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> st_n && !ck1 && !eos);
endmodule

// File: tb/test_pda_timing_gen.sv
`timescale 1ns/1ps
module test_pda_timing_gen;
  localparam int NPIX = 8, PH = 3, SMP_W = 2, HLD_W = 4, RST_W = 6;
  localparam int INT_MIN = 100, INT_MAX = 300, IW = 12;

  typedef struct {
    int    mask;
    int    gap;
    string req;
  } item_t;

  logic clk = 0, rst_n = 0, start_req = 0, hi_gain = 0;
  logic [IW-1:0] integ_len = 150;
  logic st_n, ck1, ck2, hold, reset_n, sample_n, clamp, adc_trig, eos, busy, gain_lvl;

  int checks = 0, errors = 0;
  int cyc = 0, last_evt = 0, last_rst_rise = 0, exp_int = -1;
  int ck_bad = 0, ck1_rises_st = 0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pda_timing_gen #(.NPIX(NPIX), .PH(PH), .SMP_W(SMP_W), .HLD_W(HLD_W), .RST_W(RST_W),
    .INT_MIN(INT_MIN), .INT_MAX(INT_MAX), .IW(IW)) i_pda_timing_gen (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .hi_gain(hi_gain), .integ_len(integ_len),
    .st_n(st_n), .ck1(ck1), .ck2(ck2), .hold(hold), .reset_n(reset_n), .sample_n(sample_n),
    .clamp(clamp), .adc_trig(adc_trig), .eos(eos), .busy(busy), .gain_lvl(gain_lvl));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_of(input int v);
    return v < INT_MIN ? INT_MIN : (v > INT_MAX ? INT_MAX : v);
  endfunction

  task automatic push(input int mask, input int gap, input string req);
    item_t it;
    it.mask = mask; it.gap = gap; it.req = req;
    q.push_back(it);
  endtask

  // event bits: 0 smp fall,1 smp rise,2 hold rise,3 hold fall,4 rst fall,5 rst rise,
  // 6 clamp rise,7 clamp fall,8 st fall,9 st rise,10 trig,11 eos rise,12 eos fall,13 busy fall,14 busy rise
  task automatic run_frame(input int len, input bit first);
    int m;
    integ_len = len[IW-1:0];
    exp_int = first ? -1 : eff_of(len) + SMP_W + 1;
    push(1 << 14, -1, "R1");
    push(1 << 0, -1, "R4");
    push((1 << 1) | (1 << 2), SMP_W, "R2");
    push((1 << 3) | (1 << 4), HLD_W, "R2");
    push((1 << 5) | (1 << 6) | (1 << 0), RST_W, "R2");
    push((1 << 7) | (1 << 1) | (1 << 8), RST_W, "R6");
    for (int k = 1; k <= NPIX; k++) begin
      m = 1 << 10;
      if (k == 1) m |= 1 << 9;
      if (k == NPIX - 1) m |= 1 << 11;
      if (k == NPIX) m |= 1 << 12;
      push(m, 2 * PH, "R8/R9");
    end
    push(1 << 13, PH, "R12");
    ck1_rises_st = 0;
    ck_bad = 0;
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    check(busy == 1, "R1 busy after request", busy, 1);
  endtask

  // monitor
  initial begin
    logic p_smp, p_hold, p_rst, p_clp, p_st, p_eos, p_busy, p_ck1;
    int mask;
    item_t it;
    p_smp = 1; p_hold = 0; p_rst = 1; p_clp = 0; p_st = 1; p_eos = 0; p_busy = 0; p_ck1 = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        mask = 0;
        if (p_smp && !sample_n) mask |= 1 << 0;
        if (!p_smp && sample_n) mask |= 1 << 1;
        if (!p_hold && hold)    mask |= 1 << 2;
        if (p_hold && !hold)    mask |= 1 << 3;
        if (p_rst && !reset_n)  mask |= 1 << 4;
        if (!p_rst && reset_n)  mask |= 1 << 5;
        if (!p_clp && clamp)    mask |= 1 << 6;
        if (p_clp && !clamp)    mask |= 1 << 7;
        if (p_st && !st_n)      mask |= 1 << 8;
        if (!p_st && st_n)      mask |= 1 << 9;
        if (adc_trig)           mask |= 1 << 10;
        if (!p_eos && eos)      mask |= 1 << 11;
        if (p_eos && !eos)      mask |= 1 << 12;
        if (p_busy && !busy)    mask |= 1 << 13;
        if (!p_busy && busy)    mask |= 1 << 14;
        if (ck2 == ck1) ck_bad++;
        if (!p_ck1 && ck1 && !st_n) ck1_rises_st++;
        if (mask != 0) begin
          if (q.size() == 0) begin
            check(0, "R1 unexpected event mask", mask, 0);
          end else begin
            it = q.pop_front();
            check(mask == it.mask, {it.req, " event mask"}, mask, it.mask);
            if (it.gap >= 0)
              check(cyc - last_evt == it.gap, {it.req, " event gap"}, cyc - last_evt, it.gap);
          end
          if (mask & (1 << 5)) last_rst_rise = cyc;
          if ((mask & (1 << 2)) && exp_int >= 0)
            check(cyc - last_rst_rise == exp_int, "R4/R5 reset-to-hold interval",
                  cyc - last_rst_rise, exp_int);
          last_evt = cyc;
        end
        p_smp = sample_n; p_hold = hold; p_rst = reset_n; p_clp = clamp; p_st = st_n;
        p_eos = eos; p_busy = busy; p_ck1 = ck1;
      end
    end
  end

  task automatic finish_frame();
    wait (busy == 0);
    repeat (2) @(negedge clk);
    check(ck1_rises_st == 1, "R6 ck1 rises in start window", ck1_rises_st, 1);
    check(ck_bad == 0, "R7 ck2 complement of ck1", ck_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({st_n, ck1, ck2, hold, reset_n, sample_n, clamp, adc_trig, eos, busy} == 10'b1010110000,
          "R3 reset levels", {st_n, ck1, ck2, hold, reset_n, sample_n, clamp, adc_trig, eos, busy},
          10'b1010110000);
    rst_n = 1;
    @(negedge clk);
    hi_gain = 1; @(negedge clk);
    check(gain_lvl == 0, "R11 high gain level", gain_lvl, 0);
    hi_gain = 0; @(negedge clk);
    check(gain_lvl == 1, "R11 low gain level", gain_lvl, 1);

    run_frame(150, 1);
    finish_frame();
    check(st_n && !ck1 && ck2 && reset_n && sample_n && !hold && !clamp && !eos,
          "R3 idle levels", 0, 1);

    run_frame(150, 0);
    wait (st_n == 0);
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    finish_frame();
    repeat (30) @(negedge clk);
    check(busy == 0, "R1 request during scan ignored", busy, 0);

    run_frame(20, 0);
    finish_frame();
    run_frame(1000, 0);
    finish_frame();
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R2 all expected events seen", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired actual=busy expected=idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule